// File: doc/BRIEF.md
# Keypad-Programmed Countdown Timer Controller

This controller sits between a registered keypad encoder and the user-facing outputs of a simple interval timer. The operator types up to two decimal digits. Each new digit moves the earlier units digit into the tens place. The start key then turns the two-digit decimal entry into a 7-bit binary count of seconds. The controller latches that count and counts it down, one step per 1 Hz tick pulse.

While the interval runs, the ready LED follows a 2 Hz square input so that it blinks. When the count reaches zero, the controller passes a tone square wave to the buzzer for a fixed ten ticks and then returns to entry. The clear key returns the whole block to its entry state at any time.

The design has three states:

- `ST_ENTRY`: digits are collected. The ready LED is steadily on.
- `ST_RUN`: the interval counts down.
- `ST_ALARM`: the tone burst plays.

The transitions are:

- **clear**: any state goes to `ST_ENTRY` when the clear key is pressed.
- **start**: `ST_ENTRY` goes to `ST_RUN` when the start key is pressed with a nonzero entry.
- **expire**: `ST_RUN` goes to `ST_ALARM` on the tick that takes the count from 1 to 0.
- **tone done**: `ST_ALARM` goes to `ST_ENTRY` on the tenth tick of the burst.

Top module: `kp_countdown_ctrl`

## Requirements
- R1: After reset, the block is in `ST_ENTRY` with `ready_led`=1, `timing_active`=0, `buzzer`=0 and `time_loaded`=0.
- R2: In `ST_ENTRY`, a strobe with key code 0 to 9 shifts the entry: the previous units digit becomes tens and the key becomes units. The entry value is tens*10+units, so after the keys 1,2,3 the value is 23.
- R3: A start key (code 4'hF) pressed in `ST_ENTRY` with a nonzero entry sets `time_loaded` to the entry value and raises `timing_active` one cycle after the strobe.
- R4: A start key pressed while the entry value is zero is ignored: the block stays in `ST_ENTRY` and `time_loaded` is unchanged.
- R5: In `ST_RUN`, each `tick_1hz` pulse decrements the count by one. `timing_active` stays high after the first N-1 ticks of an N-second interval and drops in the cycle after the Nth tick.
- R6: In `ST_RUN`, `ready_led` equals `sq_2hz`.
- R7: After expiry, the block is in `ST_ALARM`: `buzzer` equals `tone_sq` and `ready_led`=0. After 10 ticks it returns to `ST_ENTRY`, where `buzzer`=0 and `ready_led`=1.
- R8: A clear key (code 4'hC) in any state returns the block to `ST_ENTRY` in the next cycle, with `time_loaded` and the digit entry both zero.
- R9: Key codes A, B, D and E are ignored in every state. Digit keys and the start key are ignored in `ST_RUN` and `ST_ALARM`, where `time_loaded` stays unchanged.
- R10: A clear key arriving in the same cycle as a tick pulse takes priority. The block ends in `ST_ENTRY`.
- R11: The entry 9,9 loads the binary value 7'b1100011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | One-cycle strobe marking a new key code |
| key_code | input | 4 | Key code: 0-9 digits, F start, C clear |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| sq_2hz | input | 1 | 2 Hz square wave used for blinking |
| tone_sq | input | 1 | Audible square wave for the buzzer |
| time_loaded | output | 7 | Binary seconds value latched at start |
| ready_led | output | 1 | Ready indicator: on in entry, blinking while timing |
| timing_active | output | 1 | High while the interval counts down |
| buzzer | output | 1 | Buzzer drive, gated tone during the alarm |

## Verification
The hardest situations to reach from the ports are the last tick of an interval and the tenth tick of the tone burst. Each needs exactly the right number of tick pulses after a known load. Another is a clear key that lands on the same cycle as a tick. The stimulus reaches these by entering random digit strings from a fixed seed, with ignored codes mixed in, and then counting ticks while checking the outputs after every one. Directed cases add a zero start, a 99-second load, clear keys during both the run and the alarm, and a clear key that coincides with a tick.

// File: rtl/kpt_pkg.sv
package kpt_pkg;
    localparam int KEY_W   = 4;
    localparam int DIGIT_W = 4;

    localparam logic [KEY_W-1:0] KEY_START = 4'hF;
    localparam logic [KEY_W-1:0] KEY_CLEAR = 4'hC;
    localparam logic [KEY_W-1:0] KEY_MAXDIG = 4'd9;

    typedef enum logic [1:0] {
        ST_ENTRY = 2'd0,
        ST_RUN   = 2'd1,
        ST_ALARM = 2'd2
    } kpt_state_e;
endpackage

// File: rtl/kpt_digit_entry.sv
module kpt_digit_entry
    import kpt_pkg::*;
#(
    parameter int VAL_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift_en,
    input  logic [DIGIT_W-1:0] digit_in,
    output logic [VAL_W-1:0]   value
);
    localparam logic [VAL_W-1:0] MAX_VAL = VAL_W'(99);

    logic [DIGIT_W-1:0] tens_q;
    logic [DIGIT_W-1:0] units_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tens_q  <= '0;
            units_q <= '0;
        end else if (clr) begin
            tens_q  <= '0;
            units_q <= '0;
        end else if (shift_en) begin
            tens_q  <= units_q;
            units_q <= digit_in;
        end
    end

    // tens*10 as (tens*8)+(tens*2), then add units
    logic [VAL_W-1:0] tens_w;
    logic [VAL_W-1:0] units_w;
    assign tens_w  = VAL_W'(tens_q);
    assign units_w = VAL_W'(units_q);
    assign value   = (tens_w << 3) + (tens_w << 1) + units_w;

    // R2
    value_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        value <= MAX_VAL);

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr) |=> (tens_q == $past(units_q)) && (units_q == $past(digit_in)));
endmodule

// File: rtl/kpt_down_counter.sv
module kpt_down_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         at_one
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign count  = cnt_q;
    assign at_one = (cnt_q == W'(1));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !clr && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - W'(1)));

    // R8
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/kp_countdown_ctrl.sv
module kp_countdown_ctrl
    import kpt_pkg::*;
#(
    parameter int SEC_W     = 7,
    parameter int TONE_SECS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_valid,
    input  logic [3:0]       key_code,
    input  logic             tick_1hz,
    input  logic             sq_2hz,
    input  logic             tone_sq,
    output logic [SEC_W-1:0] time_loaded,
    output logic             ready_led,
    output logic             timing_active,
    output logic             buzzer
);
    localparam int TONE_W = $clog2(TONE_SECS + 1);

    kpt_state_e state_q, state_d;

    logic             key_clr, key_go, key_dig;
    logic             start_ok, expire, tone_done;
    logic [SEC_W-1:0] entry_val;
    logic [SEC_W-1:0] run_cnt;
    logic             run_last;
    logic [TONE_W-1:0] tone_cnt;
    logic             tone_last;
    logic [SEC_W-1:0] loaded_q;

    // key decode
    assign key_clr = key_valid && (key_code == KEY_CLEAR);
    assign key_go  = key_valid && (key_code == KEY_START);
    assign key_dig = key_valid && (key_code <= KEY_MAXDIG);

    assign start_ok  = (state_q == ST_ENTRY) && key_go && (entry_val != '0);
    assign expire    = (state_q == ST_RUN) && tick_1hz && run_last;
    assign tone_done = (state_q == ST_ALARM) && tick_1hz && tone_last;

    kpt_digit_entry #(
        .VAL_W(SEC_W)
    ) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (key_clr || start_ok),
        .shift_en (key_dig && (state_q == ST_ENTRY)),
        .digit_in (key_code),
        .value    (entry_val)
    );

    kpt_down_counter #(
        .W(SEC_W)
    ) u_run_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (key_clr),
        .load     (start_ok),
        .load_val (entry_val),
        .dec      ((state_q == ST_RUN) && tick_1hz),
        .count    (run_cnt),
        .at_one   (run_last)
    );

    kpt_down_counter #(
        .W(TONE_W)
    ) u_tone_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (key_clr),
        .load     (expire),
        .load_val (TONE_W'(TONE_SECS)),
        .dec      ((state_q == ST_ALARM) && tick_1hz),
        .count    (tone_cnt),
        .at_one   (tone_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ENTRY: if (start_ok)  state_d = ST_RUN;
            ST_RUN:   if (expire)    state_d = ST_ALARM;
            ST_ALARM: if (tone_done) state_d = ST_ENTRY;
            default:                 state_d = ST_ENTRY;
        endcase
        if (key_clr) state_d = ST_ENTRY;
    end

    // state and loaded-value registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_ENTRY;
            loaded_q <= '0;
        end else begin
            state_q <= state_d;
            if (key_clr) begin
                loaded_q <= '0;
            end else if (start_ok) begin
                loaded_q <= entry_val;
            end
        end
    end

    // outputs
    always_comb begin
        ready_led     = 1'b1;
        timing_active = 1'b0;
        buzzer        = 1'b0;
        unique case (state_q)
            ST_ENTRY: begin
                ready_led = 1'b1;
            end
            ST_RUN: begin
                ready_led     = sq_2hz;
                timing_active = 1'b1;
            end
            ST_ALARM: begin
                ready_led = 1'b0;
                buzzer    = tone_sq;
            end
            default: begin
                ready_led = 1'b1;
            end
        endcase
    end

    assign time_loaded = loaded_q;

    // R3
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ENTRY) && key_go && (entry_val != '0))
        |=> ((state_q == ST_RUN) && (time_loaded == $past(entry_val))));

    // R4
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ENTRY) && key_go && (entry_val == '0))
        |=> ((state_q == ST_ENTRY) && $stable(time_loaded)));

    // R5
    expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && tick_1hz && (run_cnt == SEC_W'(1)) && !key_clr)
        |=> (state_q == ST_ALARM));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_clr |=> ((state_q == ST_ENTRY) && (time_loaded == '0) && (entry_val == '0)));

    // R9
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_ENTRY) && !key_clr) |=> $stable(time_loaded));

    // R10
    clear_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_clr && tick_1hz) |=> (!timing_active && !buzzer && (tone_cnt == '0)));
endmodule

// File: tb/kp_countdown_ctrl_bench.sv
`timescale 1ns/1ps
module kp_countdown_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_valid = 1'b0;
    logic [3:0] key_code = 4'h0;
    logic       tick_1hz = 1'b0;
    logic       sq_2hz = 1'b0;
    logic       tone_sq = 1'b0;
    logic [6:0] time_loaded;
    logic       ready_led, timing_active, buzzer;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    kp_countdown_ctrl u_kp_countdown_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .key_valid     (key_valid),
        .key_code      (key_code),
        .tick_1hz      (tick_1hz),
        .sq_2hz        (sq_2hz),
        .tone_sq       (tone_sq),
        .time_loaded   (time_loaded),
        .ready_led     (ready_led),
        .timing_active (timing_active),
        .buzzer        (buzzer)
    );

    // bench model of the entry register
    int m_tens = 0;
    int m_units = 0;

    function automatic int exp_value(int t, int u);
        return t * 10 + u;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic settle();
        sq_2hz  = 1'($urandom);
        tone_sq = 1'($urandom);
        #1;
    endtask

    task automatic press(logic [3:0] code);
        @(negedge clk);
        key_valid = 1'b1;
        key_code  = code;
        @(negedge clk);
        key_valid = 1'b0;
        settle();
    endtask

    task automatic tick_once();
        repeat (int'($urandom_range(0, 2))) @(negedge clk);
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        settle();
    endtask

    task automatic enter_digit(int d);
        press(4'(d));
        m_tens  = m_units;
        m_units = d;
    endtask

    task automatic clear_all();
        press(4'hC);
        m_tens = 0;
        m_units = 0;
        check(!timing_active && ready_led && !buzzer && time_loaded == 0,
              "R8 clear to entry", {timing_active, ready_led, buzzer}, 3'b010);
    endtask

    // runs a full interval plus tone from a started state
    task automatic run_interval(int v);
        for (int k = 1; k <= v; k++) begin
            if (k == 2 && v > 3) begin
                press(4'h3);
                press(4'hF);
                press(4'hA);
                check(timing_active && time_loaded == 7'(v), "R9 keys ignored while timing",
                      time_loaded, v);
            end
            tick_once();
            if (k < v) begin
                check(timing_active == 1'b1, "R5 still timing", timing_active, 1);
                check(ready_led == sq_2hz, "R6 led blinks", ready_led, sq_2hz);
            end else begin
                check(timing_active == 1'b0, "R5 expiry", timing_active, 0);
            end
        end
        for (int k = 1; k <= 10; k++) begin
            if (k < 10) begin
                check(buzzer == tone_sq && !ready_led, "R7 tone burst",
                      {buzzer, ready_led}, {tone_sq, 1'b0});
            end
            if (k == 5) begin
                press(4'h7);
                press(4'hF);
                check(time_loaded == 7'(v) && !timing_active, "R9 keys ignored in tone",
                      time_loaded, v);
            end
            tick_once();
        end
        check(ready_led && !buzzer && !timing_active, "R7 back to entry",
              {ready_led, buzzer, timing_active}, 3'b100);
    endtask

    initial begin
        int seed;
        int v;
        seed = int'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check(ready_led && !timing_active && !buzzer && time_loaded == 0, "R1 reset state",
              {ready_led, timing_active, buzzer}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(ready_led && !timing_active && !buzzer && time_loaded == 0, "R1 after release",
              time_loaded, 0);

        // R4: zero start ignored
        press(4'hF);
        check(!timing_active && time_loaded == 0, "R4 zero start", timing_active, 0);
        enter_digit(0);
        enter_digit(0);
        press(4'hF);
        check(!timing_active && time_loaded == 0, "R4 zero entry start", timing_active, 0);

        // R2: three digits keep last two
        enter_digit(1);
        enter_digit(2);
        enter_digit(3);
        press(4'hF);
        check(time_loaded == 7'd23, "R2 shift keeps last two", time_loaded, 23);
        check(timing_active, "R3 start", timing_active, 1);
        run_interval(23);

        // R11: 99
        clear_all();
        enter_digit(9);
        enter_digit(9);
        press(4'hF);
        check(time_loaded == 7'b1100011, "R11 ninety-nine", time_loaded, 99);
        // R8: clear mid-run
        tick_once();
        clear_all();
        tick_once();
        check(!timing_active && !buzzer && ready_led, "R8 stays idle after clear",
              timing_active, 0);

        // R10: clear with tick in same cycle during run
        enter_digit(2);
        press(4'hF);
        @(negedge clk);
        key_valid = 1'b1;
        key_code = 4'hC;
        tick_1hz = 1'b1;
        @(negedge clk);
        key_valid = 1'b0;
        tick_1hz = 1'b0;
        settle();
        check(!timing_active && !buzzer && ready_led && time_loaded == 0,
              "R10 clear beats tick", time_loaded, 0);
        m_tens = 0;
        m_units = 0;

        // R8: clear during tone
        enter_digit(1);
        press(4'hF);
        tick_once();
        check(buzzer == tone_sq && !ready_led, "R7 tone after 1s", buzzer, tone_sq);
        clear_all();

        // random trials
        for (int t = 0; t < 14; t++) begin
            clear_all();
            for (int j = 0; j < int'($urandom_range(1, 4)); j++) begin
                int r;
                r = int'($urandom_range(0, 13));
                if (r < 10) begin
                    enter_digit(r);
                end else begin
                    logic [3:0] ign;
                    ign = (r == 10) ? 4'hA : (r == 11) ? 4'hB : (r == 12) ? 4'hD : 4'hE;
                    press(ign);
                    check(!timing_active && ready_led, "R9 A/B/D/E ignored", timing_active, 0);
                end
            end
            v = exp_value(m_tens, m_units);
            press(4'hF);
            if (v == 0) begin
                check(!timing_active && time_loaded == 0, "R4 random zero start",
                      time_loaded, 0);
            end else begin
                check(timing_active && time_loaded == 7'(v), "R3 random load",
                      time_loaded, v);
                m_tens = 0;
                m_units = 0;
                run_interval(v);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule